// File: doc/BRIEF.md
# Periodic Reloading Local Timer

A single down-counting timer with a 28-bit reload value, programmed through a small register port. The counter advances once for each cycle in which the reference tick-enable input is high. When it has counted a full period, it raises a sticky interrupt flag and reloads itself, so the timer keeps running periodically until software turns it off. The interrupt request output is high whenever the flag and the interrupt-enable bit are both set. A separate router decides which core receives the request.

Software sets up the timer with one write to the control word, which holds the reload value, the timer enable, the interrupt enable and the flag. Writing the control word with the enable bit set starts a new countdown from the reload value just written. The flag is cleared through a separate acknowledge word. The same acknowledge write can also restart the countdown from the current reload value. Reads of the acknowledge word return zero.

Top module: `reload_timer`

## Requirements
- R1: After reset, the control word reads 0x0000_0000, `irq_o` is low and the timer does not count.
- R2: Control word layout: bits [27:0] are the reload value, bit 28 enables the timer, bit 29 enables the interrupt and bit 31 is the flag. Bit 30 always reads 0. A control write replaces all four fields, the flag included.
- R3: A control write with bit 28 set loads the counter with the written reload value N. The flag then sets on the edge of the N-th following cycle in which `tick_i` is high. Cycles with `tick_i` low do not count.
- R4: At expiry the counter reloads automatically, so each later period is again N ticks long.
- R5: A control write with bit 28 clear stops the counter. No flag sets after that, whatever `tick_i` does.
- R6: An acknowledge write with bit 31 set clears the flag. An acknowledge write with bit 31 clear leaves the flag unchanged.
- R7: An acknowledge write with bit 30 set restarts the countdown from the stored reload value while the timer is enabled. The same write has no effect while the timer is disabled.
- R8: Reads at the acknowledge offset return 0. Reads at any offset other than the control word also return 0.
- R9: `irq_o` is high exactly when the flag and the interrupt-enable bit are both set. A flag that is set while interrupts are disabled stays visible in the control word.
- R10: With the timer enabled and a reload value of 0, the timer stays idle and never sets the flag.
- R11: If an expiry and a flag-clearing acknowledge fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Reference tick enable; the counter advances once per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte offset: control at 0x0, acknowledge at 0x4 |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request to the router |

## Verification
The period is measured from the enabling write to the rise of `irq_o` over a table of reload values and tick spacings. A count that advanced on every clock, instead of only on ticks, would show up as a wrong period once ticks are spaced. Each table entry then clears the flag and measures a second period, which separates automatic reload from a one-shot timer. Directed cases cover the following:
- stopping the timer in the middle of a count;
- a restart requested through the acknowledge word, with the timer enabled and with it disabled;
- a reload value of zero;
- a flag that is set while the interrupt is masked;
- an acknowledge that lands on the same edge as an expiry.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;
  localparam int DATA_W   = 32;
  localparam int RELOAD_W = 28;
  localparam int EN_BIT   = 28;
  localparam int IE_BIT   = 29;
  localparam int RSTRT_BIT = 30;
  localparam int FLAG_BIT = 31;

  typedef struct packed {
    logic                flag;
    logic                ie;
    logic                en;
    logic [RELOAD_W-1:0] reload;
  } ctrl_t;

  function automatic logic [DATA_W-1:0] pack_ctrl(ctrl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[RELOAD_W-1:0] = c.reload;
    w[EN_BIT]       = c.en;
    w[IE_BIT]       = c.ie;
    w[FLAG_BIT]     = c.flag;
    return w;
  endfunction
endpackage

// File: rtl/reload_timer_counter.sv
module reload_timer_counter #(
  parameter int W = 28
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         run_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         stop_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         expire_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic         adv;

  // a load or stop in the same cycle swallows the tick
  assign adv      = run_i && tick_i && !load_i && !stop_i;
  assign expire_o = adv && (cnt_q == ONE);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (load_i)   cnt_q <= load_val_i;
    else if (stop_i)   cnt_q <= '0;
    else if (expire_o) cnt_q <= reload_i;
    else if (adv)      cnt_q <= cnt_q - ONE;
  end
endmodule

// File: rtl/reload_timer_regs.sv
module reload_timer_regs
  import reload_timer_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h0,
  parameter logic [ADDR_W-1:0] ACK_OFS  = 'h4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                expire_i,
  output ctrl_t               ctrl_o,
  output logic                ctrl_wr_o,
  output logic                ack_clr_o,
  output logic                load_o,
  output logic [RELOAD_W-1:0] load_val_o,
  output logic                stop_o,
  output logic [DATA_W-1:0]   rdata_o
);
  ctrl_t ctrl_q;
  logic  ack_wr;

  assign ctrl_wr_o = wr_en_i && (addr_i == CTRL_OFS);
  assign ack_wr    = wr_en_i && (addr_i == ACK_OFS);
  assign ack_clr_o = ack_wr && wdata_i[FLAG_BIT];

  always_comb begin
    load_o     = 1'b0;
    load_val_o = ctrl_q.reload;
    stop_o     = 1'b0;
    if (ctrl_wr_o) begin
      load_o     = wdata_i[EN_BIT];
      stop_o     = !wdata_i[EN_BIT];
      load_val_o = wdata_i[RELOAD_W-1:0];
    end else if (ack_wr && wdata_i[RSTRT_BIT] && ctrl_q.en) begin
      load_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_wr_o) begin
      ctrl_q.reload <= wdata_i[RELOAD_W-1:0];
      ctrl_q.en     <= wdata_i[EN_BIT];
      ctrl_q.ie     <= wdata_i[IE_BIT];
      ctrl_q.flag   <= wdata_i[FLAG_BIT];
    end else if (expire_i) begin
      ctrl_q.flag <= 1'b1;  // expiry beats a same-cycle clear
    end else if (ack_clr_o) begin
      ctrl_q.flag <= 1'b0;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign rdata_o = (addr_i == CTRL_OFS) ? pack_ctrl(ctrl_q) : '0;
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import reload_timer_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h0,
  parameter logic [ADDR_W-1:0] ACK_OFS  = 'h4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  ctrl_t               ctrl;
  logic                ctrl_wr, ack_clr, load, stop, expire, run;
  logic [RELOAD_W-1:0] load_val, cnt_q;

  assign run = ctrl.en && (ctrl.reload != '0);

  reload_timer_regs #(
    .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .ACK_OFS(ACK_OFS)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .expire_i  (expire),
    .ctrl_o    (ctrl),
    .ctrl_wr_o (ctrl_wr),
    .ack_clr_o (ack_clr),
    .load_o    (load),
    .load_val_o(load_val),
    .stop_o    (stop),
    .rdata_o
  );

  reload_timer_counter #(.W(RELOAD_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .run_i     (run),
    .load_i    (load),
    .load_val_i(load_val),
    .stop_i    (stop),
    .reload_i  (ctrl.reload),
    .cnt_o     (cnt_q),
    .expire_o  (expire)
  );

  assign irq_o = ctrl.flag && ctrl.ie;
endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk #(
  parameter int W = 28
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         irq_o,
  input logic         en,
  input logic         flag,
  input logic [W-1:0] reload,
  input logic [W-1:0] cnt_q,
  input logic         expire,
  input logic         ctrl_wr,
  input logic         ack_clr
);
  assert_expire_sets_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> flag);

  assert_disabled_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !expire);

  assert_zero_reload_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && reload == '0) |-> !expire);

  assert_ack_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_clr && !expire && !ctrl_wr) |=> !flag);

  assert_clash_keeps_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_clr && expire) |=> flag);

  assert_irq_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(expire) || $past(ctrl_wr)));

  assert_count_bounded_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && reload != '0) |-> (cnt_q != '0 && cnt_q <= reload));
endmodule

bind reload_timer reload_timer_chk #(.W(reload_timer_pkg::RELOAD_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .irq_o   (irq_o),
  .en      (ctrl.en),
  .flag    (ctrl.flag),
  .reload  (ctrl.reload),
  .cnt_q   (cnt_q),
  .expire  (expire),
  .ctrl_wr (ctrl_wr),
  .ack_clr (ack_clr)
);

// File: tb/reload_timer_test.sv
module reload_timer_test;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [3:0] A_CTRL = 4'h0, A_ACK = 4'h4, A_NONE = 4'h8;
  localparam logic [31:0] EN = 32'h1000_0000, IE = 32'h2000_0000;
  localparam logic [31:0] RST = 32'h4000_0000, FLG = 32'h8000_0000;
  // {reload, tick spacing}
  localparam int VEC [6][2] = '{'{1,1}, '{2,1}, '{5,1}, '{3,2}, '{4,3}, '{7,4}};

  logic clk = 0, rst_ni = 0, tick = 0, wr_en = 0;
  logic [3:0]  addr = A_CTRL;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reload_timer uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(posedge clk); #1;
    wr_en = 0; addr = A_CTRL;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata; addr = A_CTRL;
  endtask

  task automatic run(int n);
    tick = 1;
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    tick = 0;
  endtask

  // edges until irq rises, tick every gap-th cycle
  task automatic measure(int gap, int lim, output int n);
    n = 0;
    for (int k = 0; k < lim; k++) begin
      tick = ((k % gap) == gap - 1);
      @(posedge clk); #1;
      n++;
      if (irq) break;
    end
    tick = 0;
    if (!irq) n = -1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    rd(A_CTRL, d); check("R1 ctrl after reset", d, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    run(10);
    check("R1 no count after reset", {31'b0, irq}, 32'h0);

    // R3 R4: table walk
    for (int v = 0; v < 6; v++) begin
      wr(A_CTRL, EN | IE | 32'(VEC[v][0]));
      measure(VEC[v][1], 200, n);
      check("R3 first period", 32'(n), 32'(VEC[v][0] * VEC[v][1]));
      wr(A_ACK, FLG);
      check("R6 ack clears", {31'b0, irq}, 32'h0);
      measure(VEC[v][1], 200, n);
      check("R4 reload period", 32'(n), 32'(VEC[v][0] * VEC[v][1]));
      wr(A_CTRL, 32'h0);
    end

    // R2 layout
    wr(A_CTRL, 32'h7FFF_FFFF);
    rd(A_CTRL, d); check("R2 readback bit30 zero", d, 32'h3FFF_FFFF);
    wr(A_CTRL, 32'hC000_0005);
    rd(A_CTRL, d); check("R2 flag written", d, 32'h8000_0005);
    check("R9 masked flag no irq", {31'b0, irq}, 32'h0);

    // R8
    rd(A_ACK, d); check("R8 ack reads zero", d, 32'h0);
    rd(A_NONE, d); check("R8 unmapped reads zero", d, 32'h0);

    // R6 ack without bit 31
    wr(A_CTRL, FLG | IE);
    check("R9 irq flag and ie", {31'b0, irq}, 32'h1);
    wr(A_ACK, 32'h0);
    check("R6 ack w/o bit31 keeps flag", {31'b0, irq}, 32'h1);
    wr(A_ACK, FLG);
    check("R6 ack clears flag", {31'b0, irq}, 32'h0);

    // R9 flag with ie clear
    wr(A_CTRL, EN | 32'd2);
    run(2);
    rd(A_CTRL, d); check("R9 flag visible while masked", d, FLG | EN | 32'd2);
    check("R9 irq low while masked", {31'b0, irq}, 32'h0);
    wr(A_CTRL, FLG | IE);
    check("R9 irq after ie set", {31'b0, irq}, 32'h1);
    wr(A_CTRL, 32'h0);

    // R5 stop mid-count
    wr(A_CTRL, EN | IE | 32'd4);
    run(2);
    wr(A_CTRL, IE | 32'd4);
    run(20);
    check("R5 stopped no flag", {31'b0, irq}, 32'h0);

    // R7 disabled: restart ignored
    wr(A_ACK, RST);
    run(20);
    check("R7 restart ignored when off", {31'b0, irq}, 32'h0);

    // R7 enabled restart
    wr(A_CTRL, EN | IE | 32'd5);
    run(3);
    wr(A_ACK, RST);
    measure(1, 50, n);
    check("R7 restart full period", 32'(n), 32'd5);
    wr(A_CTRL, 32'h0);

    // R10 zero reload
    wr(A_CTRL, EN | IE);
    run(30);
    rd(A_CTRL, d); check("R10 zero reload idle", d, EN | IE);

    // R11 clash
    wr(A_CTRL, EN | IE | 32'd3);
    run(3);
    check("R11 pre flag", {31'b0, irq}, 32'h1);
    wr(A_ACK, FLG);
    run(2);
    tick = 1;
    wr(A_ACK, FLG);
    tick = 0;
    check("R11 expiry beats clear", {31'b0, irq}, 32'h1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule